// File: doc/BRIEF.md
# Stepped Gain Attenuator with Soft Mute

This block scales a stream of signed 16-bit audio samples by a linear gain of `gain/63`. The gain is a 6-bit code held in a single up/down counter that saturates at both ends. A code of 63 passes samples unchanged, and a code of 0 silences them. Each sample arrives with a one-cycle strobe. The scaled result is registered on the strobe edge, so it is available one strobe after the sample that produced it.

The counter has two drive modes, chosen by `softMode`. With `softMode` low the block is in manual mode: each rising edge of the asynchronous `stepClk` moves the code by one. The edge is synchronized and edge-detected in the system clock domain first. `muteDir` sets the direction: high steps down, low steps up. With `softMode` high the block is in soft-mute mode: `stepClk` is ignored and the counter moves one code every 16 sample strobes. `muteDir` high ramps toward silence and low ramps back to full gain, so a complete ramp fits inside 1024 sample periods. Any change of `softMode`, and reset, put the code back to full scale.

Top module: `gain_ramp_atten`

## Requirements
- R1: In manual mode (`softMode`=0), each synchronized rising edge of `stepClk` changes the code by exactly one: down when `muteDir`=1, up when `muteDir`=0.
- R2: The code never wraps. Stepping down at 0 keeps 0, and stepping up at 63 keeps 63.
- R3: On a strobe, the output equals `sampleIn*code/63` as a signed quotient truncated toward zero, using the code held before that edge. Code 63 returns the sample itself, and code 0 returns 0.
- R4: After reset and after every change of `softMode`, the code is 63, and the soft-mute strobe divider restarts from zero.
- R5: In soft-mute mode, pulses on `stepClk` leave the code unchanged.
- R6: `sampleOut` is 0 after reset. It is loaded only at a clock edge with `sampleStrobe`=1 and holds its value at every other edge.
- R7: In soft-mute mode, every 16th sample strobe since the divider last restarted moves the code by one: down when `muteDir`=1, up when `muteDir`=0. The move takes effect after that strobe's own sample has been scaled.
- R8: In soft-mute mode, a ramp from 63 to 0, or from 0 to 63, completes in 1008 strobes, which is within 1024 sample periods.
- R9: In manual mode, sample strobes never change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| softMode | input | 1 | 1 = soft-mute ramp mode, 0 = manual step mode |
| muteDir | input | 1 | 1 = toward silence, 0 = toward full gain |
| stepClk | input | 1 | Asynchronous manual step clock, acts on its rising edge |
| sampleStrobe | input | 1 | One-cycle strobe marking a valid `sampleIn` |
| sampleIn | input | 16 | Signed two's-complement input sample |
| sampleOut | output | 16 | Signed scaled sample, registered on the strobe |

## Verification
The hardest condition to reach is the end of a soft-mute ramp. To get there the divider phase must line up with the code reaching a rail, and only more than a thousand strobes while the mode stays fixed can do that. The bench drives one long run of full-scale-multiple samples, about 1100 strobes down and then back up, and checks every output as it goes. Choosing samples that are multiples of 63 makes the current code readable directly from the output. A reference model tracks the divider phase, so the exact strobe at which each step lands is checked, including the saturation points at both ends.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  // Strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic loadFull;  // force code to full scale
    logic stepUp;    // move code up by one (saturating)
    logic stepDown;  // move code down by one (saturating)
  } gainCmd_t;
endpackage

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int RAMP_DIV = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     softMode,
  input  logic     muteDir,
  input  logic     stepClk,
  input  logic     sampleStrobe,
  output gainCmd_t cmd
);
  localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);

  logic [SYNC_STAGES:0] stepSync;
  logic                 modePrev;
  logic [DIV_W-1:0]     divCount;
  logic                 stepRise;
  logic                 modeFlip;
  logic                 rampTick;

  // Synchronizer chain plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) stepSync <= '0;
    else       stepSync <= {stepSync[SYNC_STAGES-1:0], stepClk};
  end

  assign stepRise = stepSync[SYNC_STAGES-1] & ~stepSync[SYNC_STAGES];
  assign modeFlip = softMode ^ modePrev;
  assign rampTick = softMode & sampleStrobe & (divCount == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= 1'b0;
      divCount <= '0;
    end else begin
      modePrev <= softMode;
      if (modeFlip || !softMode) divCount <= '0;
      else if (sampleStrobe)     divCount <= rampTick ? '0 : divCount + 1'b1;
    end
  end

  always_comb begin
    cmd = '0;
    if (modeFlip) begin
      cmd.loadFull = 1'b1;
    end else if (softMode) begin
      cmd.stepDown = rampTick & muteDir;
      cmd.stepUp   = rampTick & ~muteDir;
    end else begin
      cmd.stepDown = stepRise & muteDir;
      cmd.stepUp   = stepRise & ~muteDir;
    end
  end
endmodule

// File: rtl/gain_ramp_dp.sv
module gain_ramp_dp
  import gain_ramp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  gainCmd_t            cmd,
  input  logic                sampleStrobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [GAIN_W-1:0]   gainCode
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
  localparam logic signed [PROD_W-1:0] DIVISOR = PROD_W'((1 << GAIN_W) - 1);

  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] quotient;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainCode <= GAIN_MAX;
    end else if (cmd.loadFull) begin
      gainCode <= GAIN_MAX;
    end else if (cmd.stepUp && gainCode != GAIN_MAX) begin
      gainCode <= gainCode + 1'b1;
    end else if (cmd.stepDown && gainCode != '0) begin
      gainCode <= gainCode - 1'b1;
    end
  end

  // Signed sample times unsigned code, then a truncating divide
  assign product  = PROD_W'($signed(sampleIn)) * $signed({{(PROD_W-GAIN_W){1'b0}}, gainCode});
  assign quotient = product / DIVISOR;

  always_ff @(posedge clk) begin
    if (!rstN)             sampleOut <= '0;
    else if (sampleStrobe) sampleOut <= quotient[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/gain_ramp_atten.sv
module gain_ramp_atten
  import gain_ramp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W = 6,
  parameter int RAMP_DIV = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softMode,
  input  logic                muteDir,
  input  logic                stepClk,
  input  logic                sampleStrobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut
);
  gainCmd_t          cmd;
  logic [GAIN_W-1:0] gainCode;

  gain_ramp_ctrl #(
    .RAMP_DIV(RAMP_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .softMode(softMode),
    .muteDir(muteDir),
    .stepClk(stepClk),
    .sampleStrobe(sampleStrobe),
    .cmd(cmd)
  );

  gain_ramp_dp #(
    .SAMPLE_W(SAMPLE_W),
    .GAIN_W(GAIN_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .sampleStrobe(sampleStrobe),
    .sampleIn(sampleIn),
    .sampleOut(sampleOut),
    .gainCode(gainCode)
  );
endmodule

// File: rtl/gain_ramp_atten_chk.sv
module gain_ramp_atten_chk #(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                softMode,
  input logic                muteDir,
  input logic                sampleStrobe,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic [GAIN_W-1:0]   gainCode
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  assert_manual_dir_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!softMode && $stable(softMode) && muteDir) |=> (gainCode <= $past(gainCode)));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $stable(softMode) |=> ((gainCode == $past(gainCode)) ||
                           (gainCode == $past(gainCode) + 1'b1) ||
                           (gainCode == $past(gainCode) - 1'b1)));

  assert_zero_silence_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && gainCode == '0) |=> (sampleOut == '0));

  assert_mode_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(softMode) |=> (gainCode == GAIN_MAX));

  assert_soft_ignores_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (softMode && $stable(softMode) && !sampleStrobe) |=> $stable(gainCode));

  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(sampleOut));
endmodule

bind gain_ramp_atten gain_ramp_atten_chk #(
  .SAMPLE_W(SAMPLE_W),
  .GAIN_W(GAIN_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .softMode(softMode),
  .muteDir(muteDir),
  .sampleStrobe(sampleStrobe),
  .sampleOut(sampleOut),
  .gainCode(gainCode)
);

// File: tb/gain_ramp_atten_bench.sv
module gain_ramp_atten_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softMode = 1'b0;
  logic        muteDir = 1'b0;
  logic        stepClk = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] sampleIn = '0;
  logic [15:0] sampleOut;

  int checks = 0;
  int errors = 0;
  int modelCode = 63;
  int modelDiv = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gain_ramp_atten u_gain_ramp_atten (
    .clk(clk), .rstN(rstN), .softMode(softMode), .muteDir(muteDir),
    .stepClk(stepClk), .sampleStrobe(sampleStrobe),
    .sampleIn(sampleIn), .sampleOut(sampleOut)
  );

  function automatic int scaled(input logic [15:0] s, input int code);
    int v;
    v = $signed(s);
    return (v * code) / 63;  // integer division truncates toward zero
  endfunction

  function automatic int sat(input int c);
    return (c < 0) ? 0 : ((c > 63) ? 63 : c);
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Strobe one sample, check the registered result
  task automatic strobe(input logic [15:0] val, input string tag);
    int exp;
    @(negedge clk);
    sampleIn = val;
    sampleStrobe = 1'b1;
    exp = scaled(val, modelCode);
    if (softMode) begin
      modelDiv++;
      if (modelDiv == 16) begin
        modelDiv = 0;
        modelCode = sat(muteDir ? modelCode - 1 : modelCode + 1);
      end
    end
    @(negedge clk);
    sampleStrobe = 1'b0;
    check(tag, $signed(sampleOut), exp);
  endtask

  task automatic stepPulse();
    @(negedge clk);
    stepClk = 1'b1;
    repeat (4) @(negedge clk);
    stepClk = 1'b0;
    repeat (4) @(negedge clk);
    if (!softMode) modelCode = sat(muteDir ? modelCode - 1 : modelCode + 1);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk);
    if (m != softMode) begin
      modelCode = 63;
      modelDiv = 0;
    end
    softMode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 reset output", $signed(sampleOut), 0);
    strobe(16'd31500, "R4 reset code full");

    // Manual stepping and saturation
    muteDir = 1'b1;
    repeat (5) stepPulse();
    strobe(16'd31500, "R1 manual down");
    repeat (65) stepPulse();
    strobe(16'd31500, "R2 floor saturate");
    strobe(16'h7fff, "R3 code zero silence");
    muteDir = 1'b0;
    stepPulse();
    strobe(16'h8000, "R3 truncate negative");
    strobe(16'h7fff, "R3 truncate positive");
    repeat (10) strobe(16'd31500, "R9 strobes keep code");
    repeat (70) stepPulse();
    strobe(16'd31500, "R2 ceiling saturate");
    strobe(16'h8000, "R3 full scale identity");

    // Mode change forces full scale
    muteDir = 1'b1;
    repeat (20) stepPulse();
    strobe(16'd31500, "R1 manual down again");
    setMode(1'b1);
    strobe(16'd31500, "R4 mode change load");
    repeat (6) stepPulse();
    strobe(16'd31500, "R5 step ignored soft");

    // Full soft ramp down then up
    for (int i = 0; i < 1100; i++) strobe(16'd31500, "R7 ramp down");
    check("R8 ramp reached floor", modelCode, 0);
    strobe(16'd31500, "R8 silent after ramp");
    muteDir = 1'b0;
    for (int i = 0; i < 1100; i++) strobe(16'd31500, "R7 ramp up");
    strobe(16'd31500, "R8 full after ramp");

    // Back to manual with random stimulus
    muteDir = 1'b1;
    repeat (3) strobe(16'd31500, "R7 partial");
    setMode(1'b0);
    strobe(16'd31500, "R4 mode return load");
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      muteDir = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) stepPulse();
      strobe(16'($urandom), "R3 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule